// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block computes pointer updates for eight address registers, four on side A (A4 to A7) and four on side B (B4 to B7). It holds a 32-bit mode word. For each pointer, a 2-bit field in that word selects plain linear arithmetic or wrap-around arithmetic inside a power-of-two buffer. Two shared 5-bit size fields set the buffer length. A pointer in a wrapping mode picks one of the two. The buffer length in bytes is 2^(N+1), where N is the selected size value, so it ranges from 2 bytes up to the whole 32-bit space.

An address update presents a pointer index, a base address, a signed byte offset and a pre/post select. The path is purely combinational. It returns the write-back address, which is the updated pointer, and the effective address, which is the updated pointer in pre-modify form or the unmodified base in post-modify form. In a wrapping mode the bits above bit N come from the base unchanged. The bits at and below N are the low part of base plus offset, reduced modulo the buffer length. A buffer must therefore sit on a boundary equal to its length. The mode word is written through a simple register-transfer port and reads back at any time.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset the mode word reads as 0, so every pointer uses linear arithmetic.
- R2: A write with the strobe high updates the mode word on the clock edge. Readback shows the written bits 25..0 from the next cycle. The pointer mode for index i sits at bits 2i+1..2i, with indices 0..3 for A4..A7 and 4..7 for B4..B7. Size field 0 is bits 20..16 and size field 1 is bits 25..21.
- R3: Bits 31..26 of the mode word always read as 0, and values written to them are discarded.
- R4: While the write strobe is low, the mode word keeps its value.
- R5: Mode code 0 gives a write-back address equal to base plus offset modulo 2^32.
- R6: Mode code 1 wraps within a buffer of 2^(N+1) bytes, with N taken from size field 0. Bits above N equal the base, and bits N..0 equal (base + offset) mod 2^(N+1).
- R7: Mode code 2 wraps in the same way but takes N from size field 1.
- R8: A negative offset in a wrapping mode wraps backward to the top of the buffer, including with the smallest buffer (N = 0, 2 bytes).
- R9: With N = 31 the wrapped result equals the linear 32-bit sum.
- R10: Mode code 3 behaves as linear arithmetic and raises the reserved-mode flag. For any other code the flag is low.
- R11: With the pre select high the effective address equals the write-back address. With it low the effective address equals the base.
- R12: A new mode word takes effect on the address path in the cycle after the write edge, and address results follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Mode-word write strobe |
| cfg_wr_data | input | 32 | Mode-word write value |
| cfg_rd_data | output | 32 | Mode-word readback |
| upd_ptr_sel | input | 3 | Pointer index (0..3 = A4..A7, 4..7 = B4..B7) |
| upd_base | input | 32 | Current pointer value |
| upd_offset | input | 32 | Signed byte offset, two's complement |
| upd_pre | input | 1 | 1 = pre-modify, 0 = post-modify |
| eff_addr | output | 32 | Address used for the access |
| wb_addr | output | 32 | Updated pointer value for write-back |
| mode_rsvd | output | 1 | High when the selected pointer holds mode code 3 |

## Verification
The address outputs are combinational, so they are due in the same cycle as the inputs that produce them. The readback of a write is due one edge after the cycle in which the strobe is high. The driver changes inputs just after a rising edge and queues the expected result. The monitor pops and compares at the following falling edge, which is half a period later. For a write, the item is queued only after the capturing edge, so the comparison lands in the first cycle in which the new word can be seen. Expected addresses come from a 64-bit modulo model that keeps the base's buffer start and adds the reduced offset. This formulation differs from the mask-and-merge used in the RTL.

// File: rtl/circ_addr_pkg.sv
package circ_addr_pkg;

    localparam int ADDR_W   = 32;
    localparam int NUM_PTR  = 8;
    localparam int MODE_W   = 2;
    localparam int SZ_W     = 5;
    localparam int PTR_W    = $clog2(NUM_PTR);
    localparam int MODES_W  = NUM_PTR * MODE_W;
    localparam int STATE_W  = MODES_W + 2 * SZ_W;

    typedef enum logic [MODE_W-1:0] {
        PM_LINEAR = 2'd0,
        PM_WRAP0  = 2'd1,
        PM_WRAP1  = 2'd2,
        PM_RSVD   = 2'd3
    } ptr_mode_e;

    typedef struct packed {
        logic [SZ_W-1:0]    size1;
        logic [SZ_W-1:0]    size0;
        logic [MODES_W-1:0] modes;
    } mode_word_t;

endpackage

// File: rtl/cam_mode_reg.sv
module cam_mode_reg
    import circ_addr_pkg::*;
#(
    parameter int DATA_W = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output mode_word_t        word_q,
    output logic [DATA_W-1:0] rd_data
);

    localparam int PAD_W = DATA_W - STATE_W;

    mode_word_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d = mode_word_t'(wr_data[STATE_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_q  = st_q;
    assign rd_data = {{PAD_W{1'b0}}, st_q};

    // R2
    wr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q == mode_word_t'($past(wr_data[STATE_W-1:0]))));

    // R4
    hold_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));

endmodule

// File: rtl/cam_mode_sel.sv
module cam_mode_sel
    import circ_addr_pkg::*;
(
    input  mode_word_t       word,
    input  logic [PTR_W-1:0] ptr_sel,
    output ptr_mode_e        mode,
    output logic [SZ_W-1:0]  size_n
);

    logic [MODE_W-1:0] mode_arr [NUM_PTR];

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_field
        assign mode_arr[g] = word.modes[g*MODE_W +: MODE_W];
    end

    always_comb begin
        mode   = ptr_mode_e'(mode_arr[ptr_sel]);
        size_n = (mode == PM_WRAP1) ? word.size1 : word.size0;
    end

endmodule

// File: rtl/cam_wrap_calc.sv
module cam_wrap_calc
    import circ_addr_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] offset,
    input  ptr_mode_e         mode,
    input  logic [SZ_W-1:0]   size_n,
    output logic [ADDR_W-1:0] next_addr,
    output logic              rsvd_hit
);

    localparam int SH_W = SZ_W + 1;

    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] low_mask;
    logic [ADDR_W-1:0] eff_mask;
    logic [SH_W-1:0]   shift_amt;
    logic              wrapping;

    always_comb begin
        sum       = base + offset;
        shift_amt = SH_W'(ADDR_W - 1) - {1'b0, size_n};
        low_mask  = {ADDR_W{1'b1}} >> shift_amt;
        wrapping  = (mode == PM_WRAP0) || (mode == PM_WRAP1);
        eff_mask  = wrapping ? low_mask : {ADDR_W{1'b1}};
        next_addr = (base & ~eff_mask) | (sum & eff_mask);
        rsvd_hit  = (mode == PM_RSVD);
    end

endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
    import circ_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [31:0]       cfg_wr_data,
    output logic [31:0]       cfg_rd_data,
    input  logic [2:0]        upd_ptr_sel,
    input  logic [31:0]       upd_base,
    input  logic [31:0]       upd_offset,
    input  logic              upd_pre,
    output logic [31:0]       eff_addr,
    output logic [31:0]       wb_addr,
    output logic              mode_rsvd
);

    mode_word_t        word_q;
    ptr_mode_e         sel_mode;
    logic [SZ_W-1:0]   sel_n;

    cam_mode_reg #(.DATA_W(ADDR_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .word_q  (word_q),
        .rd_data (cfg_rd_data)
    );

    cam_mode_sel u_sel (
        .word    (word_q),
        .ptr_sel (upd_ptr_sel),
        .mode    (sel_mode),
        .size_n  (sel_n)
    );

    cam_wrap_calc u_calc (
        .base      (upd_base),
        .offset    (upd_offset),
        .mode      (sel_mode),
        .size_n    (sel_n),
        .next_addr (wb_addr),
        .rsvd_hit  (mode_rsvd)
    );

    assign eff_addr = upd_pre ? wb_addr : upd_base;

    // R11
    pre_eff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pre |-> (eff_addr == wb_addr));

    // R11
    post_eff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_pre |-> (eff_addr == upd_base));

    // R6
    circ_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_mode == PM_WRAP0 || sel_mode == PM_WRAP1) && sel_n != 5'd31)
        |-> (((wb_addr ^ upd_base) >> (6'(sel_n) + 6'd1)) == 32'd0));

    // R10
    rsvd_linear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rsvd |-> (wb_addr == upd_base + upd_offset));

    // R1
    rst_lin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_rd_data == 32'd0));

endmodule

// File: tb/tb_circ_addr_gen.sv
module tb_circ_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic [2:0]  upd_ptr_sel = '0;
    logic [31:0] upd_base = '0;
    logic [31:0] upd_offset = '0;
    logic        upd_pre = 1'b0;
    logic [31:0] eff_addr;
    logic [31:0] wb_addr;
    logic        mode_rsvd;

    always #10 clk = ~clk;

    circ_addr_gen dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .upd_ptr_sel (upd_ptr_sel),
        .upd_base    (upd_base),
        .upd_offset  (upd_offset),
        .upd_pre     (upd_pre),
        .eff_addr    (eff_addr),
        .wb_addr     (wb_addr),
        .mode_rsvd   (mode_rsvd)
    );

    typedef struct {
        bit          is_cfg;
        string       req;
        logic [31:0] exp_a;
        logic [31:0] exp_b;
        logic        exp_f;
    } sb_item_t;

    sb_item_t    sb_q[$];
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 0;
    logic [31:0] mw_model = '0;

    function automatic logic [31:0] model_next(int ptr, logic [31:0] b, logic [31:0] o);
        int md;
        int n;
        longint unsigned blk, bl, low, res;
        md = int'((mw_model >> (2 * ptr)) & 32'd3);
        if (md == 1)      n = int'(mw_model[20:16]);
        else if (md == 2) n = int'(mw_model[25:21]);
        else              return b + o;
        blk = 64'd1 << (n + 1);
        bl  = {32'd0, b};
        low = ((bl % blk) + {32'd0, o}) % blk;
        res = bl - (bl % blk) + low;
        return res[31:0];
    endfunction

    task automatic cfg_write(input logic [31:0] val, input string req);
        sb_item_t it;
        @(posedge clk); #2;
        cfg_wr_en   = 1'b1;
        cfg_wr_data = val;
        @(posedge clk); #2;
        cfg_wr_en   = 1'b0;
        mw_model    = {6'd0, val[25:0]};
        it.is_cfg = 1; it.req = req; it.exp_a = mw_model; it.exp_b = '0; it.exp_f = 0;
        sb_q.push_back(it);
    endtask

    task automatic cfg_peek(input string req);
        sb_item_t it;
        @(posedge clk); #2;
        it.is_cfg = 1; it.req = req; it.exp_a = mw_model; it.exp_b = '0; it.exp_f = 0;
        sb_q.push_back(it);
    endtask

    task automatic addr_upd(input int ptr, input logic [31:0] b, input logic [31:0] o,
                            input logic pre, input string req);
        sb_item_t it;
        logic [31:0] nx;
        @(posedge clk); #2;
        upd_ptr_sel = 3'(ptr);
        upd_base    = b;
        upd_offset  = o;
        upd_pre     = pre;
        nx = model_next(ptr, b, o);
        it.is_cfg = 0; it.req = req;
        it.exp_a = pre ? nx : b;
        it.exp_b = nx;
        it.exp_f = (((mw_model >> (2 * ptr)) & 32'd3) == 32'd3);
        sb_q.push_back(it);
    endtask

    initial begin : monitor
        sb_item_t it;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                n_checks++;
                if (it.is_cfg) begin
                    if (cfg_rd_data !== it.exp_a) begin
                        n_fail++;
                        $display("FAIL %s: readback %h expected %h", it.req, cfg_rd_data, it.exp_a);
                    end
                end else if (eff_addr !== it.exp_a || wb_addr !== it.exp_b ||
                             mode_rsvd !== it.exp_f) begin
                    n_fail++;
                    $display("FAIL %s: eff %h wb %h flag %b expected eff %h wb %h flag %b",
                             it.req, eff_addr, wb_addr, mode_rsvd, it.exp_a, it.exp_b, it.exp_f);
                end
            end
        end
    end

    initial begin : watchdog
        #(20 * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: reset word and linear behaviour
        cfg_peek("R1 reset word");
        addr_upd(3, 32'h0000_100C, 32'h0000_0010, 1'b1, "R1 linear after reset");
        // R3: reserved bits dropped
        cfg_write(32'hFFFF_FFFF, "R3 reserved bits read zero");
        // R4: hold without strobe
        cfg_peek("R4 hold value");
        // R2: field layout; A4=1 A5=2 A6=3 A7=0 B4=1 B7=2, size0=3, size1=7
        cfg_write(32'h00E3_8139, "R2 write readback");
        addr_upd(0, 32'h1000_100C, 32'h0000_0008, 1'b0, "R6 forward wrap post");
        addr_upd(0, 32'h1000_100C, 32'h0000_0008, 1'b1, "R11 pre-modify wrap");
        addr_upd(0, 32'h1000_100C, 32'hFFFF_FFEC, 1'b1, "R8 backward wrap");
        addr_upd(1, 32'h2000_01F0, 32'h0000_0020, 1'b1, "R7 size1 wrap");
        addr_upd(1, 32'h2000_0100, 32'hFFFF_FFFF, 1'b0, "R8 backward size1");
        addr_upd(2, 32'h3000_00F8, 32'h0000_0010, 1'b1, "R10 reserved mode");
        addr_upd(3, 32'hFFFF_FFF0, 32'h0000_0020, 1'b1, "R5 linear 32-bit wrap");
        addr_upd(4, 32'h4000_002E, 32'h0000_0004, 1'b1, "R6 B4 size0");
        addr_upd(7, 32'h5000_00FF, 32'h0000_0001, 1'b1, "R7 B7 size1");
        addr_upd(5, 32'h0000_0040, 32'hFFFF_FF00, 1'b0, "R11 post linear");
        // R12: new word takes effect the cycle after the edge
        cfg_write(32'h03E0_8139, "R12 rewrite size fields");
        addr_upd(0, 32'h0000_0101, 32'h0000_0001, 1'b1, "R8 smallest buffer");
        addr_upd(0, 32'h0000_0100, 32'hFFFF_FFFF, 1'b1, "R8 smallest buffer backward");
        addr_upd(1, 32'hFFFF_FFF0, 32'h0000_0030, 1'b1, "R9 full-space buffer");
        addr_upd(7, 32'h8000_0000, 32'h8000_0004, 1'b1, "R9 full-space B7");
        addr_upd(2, 32'h0000_0010, 32'h0000_0004, 1'b0, "R10 reserved post");
        cfg_write(32'h0000_0000, "R2 clear word");
        addr_upd(0, 32'h1000_100C, 32'h0000_0008, 1'b1, "R5 linear after clear");
        repeat (3) @(posedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule